// File: doc/BRIEF.md
# Character-framed SPI master

This block is the SPI master side of a serial port. Software writes one byte at a time into a holding register. The block moves the byte into a shift register and sends it MSB first on MOSI, using clock phase zero. At the same time it shifts a byte in from MISO. The idle level of SCK follows a polarity input. The bit period is a count of system clocks taken from a divisor input.

The block frames every character with the active-low select line:

- Select falls one bit period before the first SCK edge.
- Select rises one bit period after the last bit ends.
- Select then stays high for at least three bit periods before the next character can begin.

Two strobes let software pin select low across several characters and free it again. This serves slaves that need select held active between bytes.

Received bytes are presented on a data output with a ready flag. A read strobe clears the ready flag. An overrun flag records that a byte arrived while the previous one was still unread. The bit clock runs only while a character is in flight, so this mode has no receive time-out.

Top module: `spi_char_master`

## Requirements
- R1: After reset, `nss_n` is 1, `sck` equals `cfg_cpol`, `mosi` is 1, `tx_ready` is 1, and `rx_valid`, `rx_overrun` and `rx_data` are 0.
- R2: The bit period B is `cfg_div` system clocks, or 4 when `cfg_div` is below 4. In each bit, SCK holds the idle level for the first floor(B/2) clocks and the opposite level for the remaining clocks.
- R3: MOSI shows bit 7 of the character from the first clock of the lead-in period and shows bit 7−k for the whole of bit k. MOSI is 1 whenever no bit is being sent.
- R4: Select falls when a character starts. This is exactly B clocks before the first SCK edge. Select rises B clocks after the eighth bit ends.
- R5: Each character occupies 13·B clocks. This is made of B lead-in clocks, 8·B bit clocks, B trail clocks and a 3·B gap with select high. The next queued character begins one clock after the gap, so select stays high for 3·B+1 clocks between back-to-back characters.
- R6: A `cs_force` strobe holds `nss_n` low from the next clock, across characters and gaps, until a `cs_release` strobe. When both strobes arrive together, release wins.
- R7: `tx_wr` stores `tx_data` only while `tx_ready` is 1, and `tx_ready` then drops. A `tx_wr` while `tx_ready` is 0 is ignored. `tx_ready` returns to 1 on the clock after the byte moves into the shift register, and that happens on the first idle clock.
- R8: MISO is sampled at the leading SCK edge of each bit, MSB first. At the end of the eighth bit, `rx_data` takes the byte and `rx_valid` goes to 1.
- R9: `rx_rd` clears `rx_valid` and `rx_overrun`. If a byte completes while `rx_valid` is 1 and no `rx_rd` is given in that cycle, `rx_overrun` goes to 1.
- R10: `cfg_cpol` sets the idle SCK level: 0 gives idle low, and 1 gives idle high with inverted edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | DIV_W | Bit period in clocks (minimum 4); change only while idle |
| cfg_cpol | input | 1 | Idle SCK level; change only while idle |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | DATA_W | Byte to send |
| tx_ready | output | 1 | Holding register empty |
| rx_rd | input | 1 | Read strobe; clears receive flags |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | Unread byte present |
| rx_overrun | output | 1 | A byte was lost to an unread one |
| cs_force | input | 1 | Strobe: hold select low |
| cs_release | input | 1 | Strobe: end the forced hold |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| nss_n | output | 1 | Active-low slave select |

## Verification
The assertions check several relations on every cycle:

- SCK never leaves its idle level while select is high.
- MOSI does not move while SCK sits at its active level.
- A force strobe always leaves select low on the next clock.
- An accepted write always empties `tx_ready`.
- Overrun only rises while an unread byte is present.

Some properties only the bench's scenarios can show. These are the exact 13·B character length and the 3·B+1 high gap, the clamping of small divisors, and the bit order on MOSI and MISO under both polarities. The same holds for ignored writes to a full holding register and for the interplay of read strobes with overrun.

// File: rtl/spi_char_pkg.sv
// Shared types for the character-framed SPI master.
// Assumes: one character is framed by the phases below, always in this order.
package spi_char_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,   // nothing in flight
        PH_LEAD  = 3'd1,   // select low, one bit before the first edge
        PH_BITS  = 3'd2,   // data bits on the wire
        PH_TRAIL = 3'd3,   // select still low, one bit after the last bit
        PH_GAP   = 3'd4    // enforced quiet time between characters
    } phase_e;

endpackage

// File: rtl/spi_char_timer.sv
// Bit-period timer: counts system clocks within one bit period while a
// character is in flight and flags the half-bit and end-of-bit points.
// Assumes: cfg_div is stable while run is high; DIV_W >= 3.
module spi_char_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tick_mid,
    output logic             tick_end,
    output logic             late_half
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(4);

    logic [DIV_W-1:0] period;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt;

    // Clamp the divisor so that both half-bit phases are at least two clocks.
    always_comb begin
        period = (cfg_div < MIN_DIV) ? MIN_DIV : cfg_div;
        half   = period >> 1;
    end

    // Count clocks within the bit; wrap at the period, hold at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == period - 1'b1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Decode the leading-edge and end-of-bit points and the second half.
    always_comb begin
        tick_end  = run && (cnt == period - 1'b1);
        tick_mid  = run && (cnt == half - 1'b1);
        late_half = (cnt >= half);
    end

endmodule

// File: rtl/spi_char_shift.sv
// Data path: a transmit shift register that feeds MOSI MSB first, and a
// receive shift register that collects MISO MSB first.
// Assumes: load and shift_en never coincide; ones are shifted into the
// transmit register so the line rests high between characters.
module spi_char_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_sh;

    // Load a new character or advance one bit toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '1;
        end else if (load) begin
            tx_sh <= load_data;
        end else if (shift_en) begin
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
        end
    end

    // Capture MISO at each leading SCK edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (sample_en) begin
            rx_word <= {rx_word[DATA_W-2:0], miso};
        end
    end

    assign mosi = tx_sh[DATA_W-1];

endmodule

// File: rtl/spi_char_master.sv
// Character-framed SPI master (clock phase zero, MSB first).
// Sequences lead-in, data bits, trail and gap for each character, drives
// select with an optional software hold, and keeps one-entry transmit and
// receive registers with ready and overrun flags.
// Assumes: cfg_div and cfg_cpol change only while no character is queued
// or in flight.
module spi_char_master
    import spi_char_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 8,
    parameter int GAP_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_cpol,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_overrun,
    input  logic              cs_force,
    input  logic              cs_release,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              nss_n
);
    localparam int IDX_MAX = (DATA_W > GAP_BITS) ? DATA_W : GAP_BITS;
    localparam int IDX_W   = $clog2(IDX_MAX);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST_GAP = IDX_W'(GAP_BITS - 1);

    phase_e            phase;
    logic [IDX_W-1:0]  idx;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              cs_hold;
    logic              tick_mid, tick_end, late_half;
    logic              start, in_bits, publish;
    logic [DATA_W-1:0] rx_word;

    assign start   = (phase == PH_IDLE) && hold_full;
    assign in_bits = (phase == PH_BITS);
    assign publish = in_bits && tick_end && (idx == LAST_BIT);

    spi_char_timer #(.DIV_W(DIV_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (phase != PH_IDLE),
        .cfg_div   (cfg_div),
        .tick_mid  (tick_mid),
        .tick_end  (tick_end),
        .late_half (late_half)
    );

    spi_char_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_data (hold_data),
        .shift_en  (in_bits && tick_end),
        .sample_en (in_bits && tick_mid),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    // Step through the phases of one character at each end of a bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            idx   <= '0;
        end else if (start) begin
            phase <= PH_LEAD;
            idx   <= '0;
        end else if (tick_end) begin
            unique case (phase)
                PH_LEAD:  phase <= PH_BITS;
                PH_BITS: begin
                    if (idx == LAST_BIT) begin
                        phase <= PH_TRAIL;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_TRAIL: phase <= PH_GAP;
                PH_GAP: begin
                    if (idx == LAST_GAP) begin
                        phase <= PH_IDLE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // One-entry transmit holding register; writes while full are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (start) begin
            hold_full <= 1'b0;
        end else if (tx_wr && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= tx_data;
        end
    end

    // Software select hold; release takes priority over force.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_release) begin
            cs_hold <= 1'b0;
        end else if (cs_force) begin
            cs_hold <= 1'b1;
        end
    end

    // Receive register with ready and overrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end else if (publish) begin
            rx_data    <= rx_word;
            rx_valid   <= 1'b1;
            rx_overrun <= !rx_rd && (rx_valid || rx_overrun);
        end else if (rx_rd) begin
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end
    end

    // Output decode from registered state.
    always_comb begin
        tx_ready = !hold_full;
        sck      = cfg_cpol ^ (in_bits && late_half);
        nss_n    = !(cs_hold || phase == PH_LEAD || in_bits || phase == PH_TRAIL);
    end

endmodule

// File: rtl/spi_char_chk.sv
// Protocol checker for the character-framed SPI master, bound to every
// instance. Assumes: cfg_cpol changes only while idle.
module spi_char_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_cpol,
    input logic sck,
    input logic mosi,
    input logic nss_n,
    input logic cs_force,
    input logic cs_release,
    input logic tx_wr,
    input logic tx_ready,
    input logic rx_valid,
    input logic rx_overrun
);
    // R4: an active clock level only ever appears inside a select window.
    a_r4_sck_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != cfg_cpol) |-> !nss_n);

    // R3: data is held steady across the active half of each bit.
    a_r3_mosi_stable_active: assert property (@(posedge clk) disable iff (!rst_n)
        ((sck != cfg_cpol) && $past(sck != cfg_cpol)) |-> $stable(mosi));

    // R6: a force strobe without release pulls select low next cycle.
    a_r6_force_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_force && !cs_release) |=> !nss_n);

    // R7: an accepted write fills the holding register.
    a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_ready) |=> !tx_ready);

    // R9: overrun can only appear on top of an unread byte.
    a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_valid));

endmodule

bind spi_char_master spi_char_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_cpol   (cfg_cpol),
    .sck        (sck),
    .mosi       (mosi),
    .nss_n      (nss_n),
    .cs_force   (cs_force),
    .cs_release (cs_release),
    .tx_wr      (tx_wr),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_overrun (rx_overrun)
);

// File: tb/tb_spi_char_master.sv
// Bench: behavioural timeline model (cycle index within a 13-bit character
// window) compared against the design at every falling clock edge.
module tb_spi_char_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_div = 8'd4;
    logic       cfg_cpol = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_overrun;
    logic       cs_force = 1'b0, cs_release = 1'b0;
    logic       sck, mosi, nss_n;
    logic       miso = 1'b0;

    int n_checks = 0, n_fails = 0;
    bit cmp_en = 0;

    always #2.5 clk = ~clk;

    spi_char_master dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_overrun(rx_overrun), .cs_force(cs_force), .cs_release(cs_release),
        .sck(sck), .mosi(mosi), .miso(miso), .nss_n(nss_n)
    );

    // Reference model state.
    bit       m_busy, m_full, m_hold, m_valid, m_ovr;
    int       t;
    bit [7:0] m_cur, m_hdata, m_rx, m_sbyte;
    bit [7:0] slave_q[$];
    int       gaps[$];
    int       hi_run;

    function automatic int per();
        return (cfg_div < 8'd4) ? 4 : int'(cfg_div);
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each rising edge, from the inputs that edge sees.
    always @(posedge clk) begin
        int b;
        bit pre_full;
        b = per();
        if (!rst_n) begin
            m_busy = 0; m_full = 0; m_hold = 0; m_valid = 0; m_ovr = 0;
            t = 0; m_cur = 0; m_hdata = 0; m_rx = 0; m_sbyte = 0;
        end else begin
            if (cs_release) m_hold = 0; else if (cs_force) m_hold = 1;
            if (rx_rd) begin m_valid = 0; m_ovr = 0; end
            if (m_busy && t == 9*b - 1) begin
                if (m_valid) m_ovr = 1;
                m_valid = 1; m_rx = m_sbyte;
            end
            pre_full = m_full;
            if (m_busy) begin
                if (t == 13*b - 1) begin m_busy = 0; t = 0; end
                else t++;
            end else if (m_full) begin
                m_busy = 1; t = 0; m_cur = m_hdata; m_full = 0;
                m_sbyte = (slave_q.size() > 0) ? slave_q.pop_front() : 8'h00;
            end
            if (tx_wr && !pre_full) begin m_full = 1; m_hdata = tx_data; end
        end
    end

    // Slave drives MISO shortly after each edge from the model's bit position.
    always @(posedge clk) begin
        int b;
        #1;
        b = per();
        if (m_busy && t >= b && t < 9*b) miso = m_sbyte[7 - (t - b)/b];
        else miso = 1'b0;
    end

    // Compare every output against the model, away from the active edge.
    always @(negedge clk) begin
        int b, h, bit_i, w;
        bit inb, e_sck, e_mosi, e_nss;
        if (cmp_en && rst_n) begin
            b = per(); h = b / 2;
            inb = m_busy && t >= b && t < 9*b;
            bit_i = (t - b) / b; w = (t - b) % b;
            e_sck  = inb ? (cfg_cpol ^ (w >= h)) : cfg_cpol;
            e_mosi = inb ? m_cur[7 - bit_i] : ((m_busy && t < b) ? m_cur[7] : 1'b1);
            e_nss  = !(m_hold || (m_busy && t < 10*b));
            check("R2 R10 sck", {7'b0, sck}, {7'b0, e_sck});
            check("R3 mosi", {7'b0, mosi}, {7'b0, e_mosi});
            check("R4 R6 nss_n", {7'b0, nss_n}, {7'b0, e_nss});
            check("R7 tx_ready", {7'b0, tx_ready}, {7'b0, !m_full});
            check("R8 rx_valid", {7'b0, rx_valid}, {7'b0, m_valid});
            check("R8 rx_data", rx_data, m_rx);
            check("R9 rx_overrun", {7'b0, rx_overrun}, {7'b0, m_ovr});
        end
        if (rst_n) begin
            if (nss_n) hi_run++;
            else begin
                if (hi_run > 0) gaps.push_back(hi_run);
                hi_run = 0;
            end
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic write_byte(bit [7:0] d);
        while (!tx_ready) tick();
        tx_wr = 1; tx_data = d; tick(); tx_wr = 0;
    endtask

    task automatic strobe_rd(); rx_rd = 1; tick(); rx_rd = 0; endtask

    task automatic wait_idle();
        tick();
        while (m_busy || m_full) tick();
        tick();
    endtask

    initial begin
        hi_run = 0;
        repeat (3) tick();
        rst_n = 1;
        #1;
        // R1: reset state
        check("R1 nss_n", {7'b0, nss_n}, 8'd1);
        check("R1 sck", {7'b0, sck}, 8'd0);
        check("R1 mosi", {7'b0, mosi}, 8'd1);
        check("R1 tx_ready", {7'b0, tx_ready}, 8'd1);
        check("R1 rx_flags", {6'b0, rx_valid, rx_overrun}, 8'd0);
        check("R1 rx_data", rx_data, 8'd0);
        cmp_en = 1;

        // R2 R3 R8: plain character, idle-low clock, B=4.
        slave_q.push_back(8'h3C);
        write_byte(8'hA5);
        wait_idle();
        check("R8 byte received", rx_data, 8'h3C);
        strobe_rd();

        // R5 R9 R10: back-to-back, idle-high clock, odd period, no read.
        cfg_div = 8'd5; cfg_cpol = 1'b1; tick();
        slave_q.push_back(8'h81); slave_q.push_back(8'h7E);
        write_byte(8'h5A);
        write_byte(8'hC3);
        wait_idle();
        check("R5 select-high gap", 8'(gaps[$]), 8'(3*5 + 1));
        check("R9 overrun set", {7'b0, rx_overrun}, 8'd1);
        check("R9 newest byte kept", rx_data, 8'h7E);
        strobe_rd();
        check("R9 read clears", {6'b0, rx_valid, rx_overrun}, 8'd0);

        // R2: small divisor clamps to 4.
        cfg_div = 8'd2; cfg_cpol = 1'b0; tick();
        slave_q.push_back(8'hF0);
        write_byte(8'h0F);
        wait_idle();
        check("R2 clamped frame", rx_data, 8'hF0);
        strobe_rd();

        // R7: write while full is ignored.
        cfg_div = 8'd6; tick();
        slave_q.push_back(8'h11); slave_q.push_back(8'h22);
        write_byte(8'h96);
        write_byte(8'h69);
        check("R7 full", {7'b0, tx_ready}, 8'd0);
        tx_wr = 1; tx_data = 8'hEE; tick(); tx_wr = 0;
        check("R7 still full", {7'b0, tx_ready}, 8'd0);
        wait_idle();
        check("R7 two frames only", rx_data, 8'h22);
        strobe_rd();

        // R6: forced select across characters, release wins over force.
        cfg_div = 8'd4; tick();
        cs_force = 1; tick(); cs_force = 0;
        check("R6 forced low", {7'b0, nss_n}, 8'd0);
        slave_q.push_back(8'h55); slave_q.push_back(8'hAA);
        write_byte(8'h12);
        write_byte(8'h34);
        wait_idle();
        check("R6 held after gap", {7'b0, nss_n}, 8'd0);
        cs_force = 1; cs_release = 1; tick(); cs_force = 0; cs_release = 0;
        check("R6 release wins", {7'b0, nss_n}, 8'd1);
        strobe_rd();
        repeat (4) tick();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule